// File: doc/BRIEF.md
# Multidrop Address Filter for a 9-bit UART Receiver

This block sits between a UART deserializer and a receive FIFO on a slave node of an RS-485 multidrop bus. Each received character arrives with a valid strobe, eight data bits and a ninth bit. The ninth bit marks the character type: 1 means an address character and 0 means a data character. A small control register sets the behaviour. Together with a static slave address, it decides which characters are written to the FIFO and when an address interrupt is raised.

There are three behaviours. With multidrop handling off, the block passes every character through. With multidrop handling on and automatic detection off, software does the filtering: each address character raises an interrupt pulse and sets a sticky status flag, which software reads to clear. With automatic detection also on, the hardware filters by itself. A matching address opens the receiver and a foreign address closes it. The receiver-off bit can also be written directly, and it stops characters from reaching the FIFO.

Top module: `mdaf_top`

## Requirements
- R1: After synchronous reset, the control readback (bit 0 multidrop enable, bit 1 receiver off, bit 2 automatic detect) is 000, and `fifo_we`, `addr_irq` and `pe_flag` are 0.
- R2: A character strobed on `rx_valid` in cycle t is compared in cycle t+1, and any resulting FIFO write appears as a one-cycle `fifo_we` in cycle t+2 with `fifo_wdata` equal to the received data.
- R3: With bit 0 clear, every character is written to the FIFO (when bit 1 is clear) whatever its ninth bit, and no interrupt is raised and `pe_flag` is not set.
- R4: With bit 0 set and bit 2 clear, a character whose ninth bit is 1 raises a one-cycle `addr_irq` and sets `pe_flag`, and it is stored like any other character.
- R5: With bit 1 set, no character is written to the FIFO, except a matching address character under automatic detection (R6); in the mode of R4 address characters still raise `addr_irq`.
- R6: With bits 0 and 2 set, an address character equal to `slave_addr` is written to the FIFO, raises `addr_irq`, sets `pe_flag` and clears bit 1.
- R7: With bits 0 and 2 set, an address character not equal to `slave_addr` is not stored, raises no interrupt, and sets bit 1.
- R8: With bits 0 and 2 set, a data character is stored exactly when bit 1 is clear as updated by the preceding address character, including when the data strobe follows the address strobe in the very next cycle.
- R9: Bit 2 has no effect while bit 0 is clear: characters then behave as in R3.
- R10: `pe_flag` clears in the cycle after a `pe_rd` pulse; an interrupt that arrives at the same edge as the read leaves the flag set.
- R11: A write through `cfg_we` loads all three control bits and wins over an automatic update of bit 1 at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control value: bit 0 multidrop, bit 1 receiver off, bit 2 auto detect |
| cfg_rdata | output | 3 | Current control register value |
| slave_addr | input | DATA_W | This node's address |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received data bits |
| rx_bit9 | input | 1 | Ninth bit: 1 address, 0 data |
| pe_rd | input | 1 | Status read pulse, clears `pe_flag` |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | DATA_W | Receive FIFO write data |
| addr_irq | output | 1 | Address-detected pulse |
| pe_flag | output | 1 | Sticky address/parity status flag |

## Verification
The bench builds the block with the default 8-bit character width and drives it against a slave address of 0x5A. At that width, one-off neighbours of the address (0x5B) and arbitrary foreign values exercise the equality compare bit by bit. A vector table walks all four control combinations, so the same stimulus shows the pass-through, software-handled and hardware-filtered behaviours. Directed sequences then cover back-to-back address and data strobes, a status read that collides with a new interrupt, and a control write that collides with an automatic receiver-off update.

// File: rtl/mdaf_pkg.sv
package mdaf_pkg;

    localparam int CHAR_W_DEF = 8;
    localparam int CTRL_W     = 3;

    // Packed so that bit 0 = multidrop enable, bit 1 = receiver off, bit 2 = auto detect
    typedef struct packed {
        logic auto_en;
        logic rx_off;
        logic mode_en;
    } ctrl_t;

    typedef struct packed {
        logic store;
        logic irq;
        logic set_off;
        logic clr_off;
    } verdict_t;

    function automatic verdict_t judge(input ctrl_t c, input logic is_addr, input logic hit);
        verdict_t v;
        v = '0;
        if (!c.mode_en) begin
            v.store = !c.rx_off;
        end else if (!c.auto_en) begin
            v.store = !c.rx_off;
            v.irq   = is_addr;
        end else if (is_addr) begin
            if (hit) begin
                v.store   = 1'b1;
                v.irq     = 1'b1;
                v.clr_off = 1'b1;
            end else begin
                v.set_off = 1'b1;
            end
        end else begin
            v.store = !c.rx_off;
        end
        return v;
    endfunction

endpackage

// File: rtl/mdaf_capture.sv
module mdaf_capture #(
    parameter int DATA_W = mdaf_pkg::CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_bit9,
    output logic              stg_vld,
    output logic [DATA_W-1:0] stg_data,
    output logic              stg_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_vld  <= 1'b0;
            stg_data <= '0;
            stg_addr <= 1'b0;
        end else begin
            stg_vld <= in_vld;
            if (in_vld) begin
                stg_data <= in_data;
                stg_addr <= in_bit9;
            end
        end
    end
endmodule

// File: rtl/mdaf_ctrl_reg.sv
module mdaf_ctrl_reg
    import mdaf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_val,
    input  logic  set_off,
    input  logic  clr_off,
    output ctrl_t ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= wr_val;
        end else if (set_off) begin
            ctrl.rx_off <= 1'b1;
        end else if (clr_off) begin
            ctrl.rx_off <= 1'b0;
        end
    end
endmodule

// File: rtl/mdaf_out.sv
module mdaf_out
    import mdaf_pkg::*;
#(
    parameter int DATA_W = CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  verdict_t          vd,
    input  logic [DATA_W-1:0] data,
    input  logic              clr_req,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              irq,
    output logic              flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            we    <= 1'b0;
            wdata <= '0;
            irq   <= 1'b0;
            flag  <= 1'b0;
        end else begin
            we  <= vd.store;
            irq <= vd.irq;
            if (vd.store) begin
                wdata <= data;
            end
            if (vd.irq) begin
                flag <= 1'b1;
            end else if (clr_req) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mdaf_top.sv
module mdaf_top
    import mdaf_pkg::*;
#(
    parameter int DATA_W = CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic              pe_rd,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              addr_irq,
    output logic              pe_flag
);
    logic              stg_vld;
    logic [DATA_W-1:0] stg_data;
    logic              stg_addr;
    ctrl_t             ctrl_q;
    verdict_t          vd;
    logic              addr_hit;

    mdaf_capture #(.DATA_W(DATA_W)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (rx_valid),
        .in_data  (rx_data),
        .in_bit9  (rx_bit9),
        .stg_vld  (stg_vld),
        .stg_data (stg_data),
        .stg_addr (stg_addr)
    );

    assign addr_hit = (stg_data == slave_addr);

    always_comb begin
        vd = '0;
        if (stg_vld) begin
            vd = judge(ctrl_q, stg_addr, addr_hit);
        end
    end

    mdaf_ctrl_reg ctl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_val  (ctrl_t'(cfg_wdata)),
        .set_off (vd.set_off),
        .clr_off (vd.clr_off),
        .ctrl    (ctrl_q)
    );

    assign cfg_rdata = ctrl_q;

    mdaf_out #(.DATA_W(DATA_W)) out_i (
        .clk     (clk),
        .rst     (rst),
        .vd      (vd),
        .data    (stg_data),
        .clr_req (pe_rd),
        .we      (fifo_we),
        .wdata   (fifo_wdata),
        .irq     (addr_irq),
        .flag    (pe_flag)
    );
endmodule

// File: rtl/mdaf_checker.sv
module mdaf_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cfg_rdata,
    input logic [DATA_W-1:0] slave_addr,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              pe_rd,
    input logic              fifo_we,
    input logic [DATA_W-1:0] fifo_wdata,
    input logic              addr_irq,
    input logic              pe_flag
);
    a_r2_store_latency: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> ($past(rx_valid, 2) && fifo_wdata == $past(rx_data, 2)));

    a_r4_irq_needs_addr: assert property (@(posedge clk) disable iff (rst)
        addr_irq |-> ($past(rx_bit9, 2) && $past(cfg_rdata[0], 1)));

    a_r10_irq_sets_flag: assert property (@(posedge clk) disable iff (rst)
        addr_irq |-> pe_flag);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        ($past(pe_rd) && !addr_irq) |-> !pe_flag);

    a_r7_drop_foreign: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_valid, 2) && $past(rx_bit9, 2) && $past(rx_data, 2) != $past(slave_addr, 2)
         && $past(cfg_rdata[0], 1) && $past(cfg_rdata[2], 1)) |-> (!fifo_we && !addr_irq));

    a_r5_off_blocks: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_valid, 2) && $past(cfg_rdata[1], 1)
         && !($past(cfg_rdata[0], 1) && $past(cfg_rdata[2], 1) && $past(rx_bit9, 2))) |-> !fifo_we);
endmodule

bind mdaf_top mdaf_checker #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_rdata  (cfg_rdata),
    .slave_addr (slave_addr),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_bit9    (rx_bit9),
    .pe_rd      (pe_rd),
    .fifo_we    (fifo_we),
    .fifo_wdata (fifo_wdata),
    .addr_irq   (addr_irq),
    .pe_flag    (pe_flag)
);

// File: tb/mdaf_top_tb_top.sv
module mdaf_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam logic [DW-1:0] MY_ADDR = 8'h5A;
    localparam int NV = 16;

    // {wr, cfg[2:0], bit9, data[7:0], exp_we, exp_irq, exp_off, req}
    localparam logic [19:0] VEC [0:NV-1] = '{
        {1'b1, 3'b000, 1'b0, 8'h11, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 data passes
        {1'b0, 3'b000, 1'b1, 8'h22, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 address passes, no irq
        {1'b1, 3'b001, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 address irq and store
        {1'b0, 3'b001, 1'b0, 8'h44, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 data stored
        {1'b1, 3'b011, 1'b1, 8'h55, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 off, irq still
        {1'b0, 3'b011, 1'b0, 8'h66, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 off, data blocked
        {1'b1, 3'b101, 1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 foreign address
        {1'b0, 3'b101, 1'b0, 8'h88, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 data dropped
        {1'b0, 3'b101, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 match opens
        {1'b0, 3'b101, 1'b0, 8'h99, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 data stored
        {1'b0, 3'b101, 1'b1, 8'h5B, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 near-miss address
        {1'b0, 3'b101, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 dropped again
        {1'b1, 3'b100, 1'b1, 8'hBB, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 auto without mode
        {1'b0, 3'b100, 1'b0, 8'hCC, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 data passes
        {1'b1, 3'b111, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 match clears off bit
        {1'b1, 3'b000, 1'b0, 8'hDD, 1'b1, 1'b0, 1'b0, 4'd3}   // R3 back to pass-through
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_wdata = '0;
    logic [2:0]    cfg_rdata;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_bit9 = 1'b0;
    logic          pe_rd = 1'b0;
    logic          fifo_we;
    logic [DW-1:0] fifo_wdata;
    logic          addr_irq;
    logic          pe_flag;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdaf_top #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .slave_addr(MY_ADDR), .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .pe_rd(pe_rd), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .addr_irq(addr_irq),
        .pe_flag(pe_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [2:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // Ends at the negedge after the output-register edge
    task automatic send_char(input logic b9, input logic [DW-1:0] d);
        @(negedge clk); rx_valid = 1'b1; rx_bit9 = b9; rx_data = d;
        @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ctrl reset", cfg_rdata, 0);
        check("R1 fifo_we reset", fifo_we, 0);
        check("R1 irq reset", addr_irq, 0);
        check("R1 pe_flag reset", pe_flag, 0);

        // R2 latency: nothing after the first edge, write after the second
        @(negedge clk); rx_valid = 1'b1; rx_bit9 = 1'b0; rx_data = 8'hC3;
        @(negedge clk); rx_valid = 1'b0;
        check("R2 no write at t+1", fifo_we, 0);
        @(negedge clk);
        check("R2 write at t+2", fifo_we, 1);
        check("R2 data at t+2", fifo_wdata, 8'hC3);
        @(negedge clk);
        check("R2 one-cycle strobe", fifo_we, 0);

        // R3 status untouched in pass-through
        send_char(1'b1, 8'h5A);
        check("R3 pe_flag unchanged", pe_flag, 0);

        for (int i = 0; i < NV; i++) begin
            automatic logic [19:0] v = VEC[i];
            automatic string tg = $sformatf("R%0d vec%0d", v[3:0], i);
            if (v[19]) write_cfg(v[18:16]);
            send_char(v[15], v[14:7]);
            check({tg, " we"}, fifo_we, v[6]);
            if (v[6]) check({tg, " data"}, fifo_wdata, v[14:7]);
            check({tg, " irq"}, addr_irq, v[5]);
            check({tg, " off bit"}, cfg_rdata[1], v[4]);
        end

        // R10 read clears the sticky flag
        check("R10 flag set before read", pe_flag, 1);
        @(negedge clk); pe_rd = 1'b1;
        @(negedge clk); pe_rd = 1'b0;
        check("R10 flag cleared", pe_flag, 0);

        // R10 interrupt and read at the same edge: flag stays set
        write_cfg(3'b001);
        @(negedge clk); rx_valid = 1'b1; rx_bit9 = 1'b1; rx_data = 8'h01;
        @(negedge clk); rx_valid = 1'b0; pe_rd = 1'b1;
        @(negedge clk); pe_rd = 1'b0;
        check("R10 irq with read", addr_irq, 1);
        check("R10 set wins over read", pe_flag, 1);

        // R8 back-to-back address then data under auto detect
        write_cfg(3'b111);
        @(negedge clk); rx_valid = 1'b1; rx_bit9 = 1'b1; rx_data = MY_ADDR;
        @(negedge clk); rx_bit9 = 1'b0; rx_data = 8'hE1;
        @(negedge clk); rx_valid = 1'b0;
        check("R8 b2b address stored", fifo_we, 1);
        check("R8 b2b address data", fifo_wdata, MY_ADDR);
        @(negedge clk);
        check("R8 b2b data stored", fifo_we, 1);
        check("R8 b2b data value", fifo_wdata, 8'hE1);

        // R11 control write collides with automatic set of the off bit
        write_cfg(3'b101);
        @(negedge clk); rx_valid = 1'b1; rx_bit9 = 1'b1; rx_data = 8'h42;
        @(negedge clk); rx_valid = 1'b0; cfg_we = 1'b1; cfg_wdata = 3'b001;
        @(negedge clk); cfg_we = 1'b0;
        check("R11 write wins", cfg_rdata, 3'b001);
        check("R7 foreign not stored", fifo_we, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule